// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a 32-bit down-counting interval timer reached through a small word-addressed slave bus with 16-bit data. Software sets a period through two 16-bit halves, then issues a start command. The counter loads the period, counts down by one every clock, and raises a sticky timeout flag when it reaches zero. In one-shot mode it then stops. In continuous mode it reloads the period and keeps going. An interrupt line follows the timeout flag whenever the interrupt enable bit is set.

Start and stop are command bits that act at the moment they are written and are never stored. The timeout flag is cleared by any write to the status word. Because the count is 32 bits and the bus is 16 bits, reading the live count takes two steps. First, software writes either snapshot address, which copies the whole count into a holding register. It then reads the two snapshot halves, which always belong to the same capture.

The counter is a two-state machine:
- `ST_IDLE`: the counter is held.
- `ST_COUNT`: the counter decrements.

Its transitions are:
- START moves it from `ST_IDLE` or `ST_COUNT` to `ST_COUNT` and loads the period.
- STOP moves it to `ST_IDLE`.
- PERIOD_WRITE moves it to `ST_IDLE` and loads the new period.
- EXPIRE_RELOAD stays in `ST_COUNT`, sets timeout and reloads the period (continuous mode at zero).
- EXPIRE_HALT moves it to `ST_IDLE` and sets timeout (one-shot mode at zero).
- TICK stays in `ST_COUNT` and decrements.

Top module: `ivl_timer_top`

## Requirements
- R1: After reset every readable word reads 0, the counter is idle and `irq` is low.
- R2: Word offsets are 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Status reads bit 0 = timeout and bit 1 = running. Control bit 0 = interrupt enable and bit 1 = continuous mode, and both read back. Control bits 2 and 3 always read 0. Both period halves read back what was written.
- R3: Writing control with bit 2 (start) set loads the full period into the counter on that write's clock edge, sets running, and the counter then decreases by one on every later edge.
- R4: For period P, the timeout flag sets on the (P+1)-th edge after the start edge. In one-shot mode, running clears on that same edge and the count stays at 0.
- R5: In continuous mode, expiry sets timeout, reloads the period and keeps running, so timeout recurs every P+1 edges.
- R6: Writing control with bit 3 (stop) set halts counting on that edge, and the count is frozen.
- R7: If a control write sets both start and stop, stop wins and the counter stays or goes idle.
- R8: Any write to status clears the timeout flag, whatever the data. If an expiry falls on the same edge, the flag stays set.
- R9: The timeout flag stays set until a status write clears it. Changing control bits does not clear it.
- R10: `irq` is high exactly when timeout is set and the interrupt enable bit is 1.
- R11: A write to offset 4 or 5 captures the whole live count into the snapshot. The snapshot halves do not change until the next such write.
- R12: Writing either period half stops the counter and loads the updated 32-bit period into the count.
- R13: Offsets 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select for the bus access |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| addr | input | 3 | Word offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
A bus write takes effect on the single clock edge at which it is presented. Read data is combinational, so the bench drives a write in the low clock phase, waits for the next falling edge, and reads back without crossing another edge. From the start edge, the timeout and the change in running are due P+1 edges later. The bench counts falling edges from the return of the start write and checks the status one edge before and exactly on that edge. Snapshot values are predicted from how many edges separate the start edge from the capture edge: a capture k edges after the start holds P-(k-1).

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    localparam int unsigned OFS_STATUS  = 0;
    localparam int unsigned OFS_CONTROL = 1;
    localparam int unsigned OFS_PER_LO  = 2;
    localparam int unsigned OFS_PER_HI  = 3;
    localparam int unsigned OFS_SNAP_LO = 4;
    localparam int unsigned OFS_SNAP_HI = 5;

    localparam int unsigned CTL_IE    = 0;
    localparam int unsigned CTL_CONT  = 1;
    localparam int unsigned CTL_START = 2;
    localparam int unsigned CTL_STOP  = 3;
endpackage

// File: rtl/tmr_regfile.sv
`timescale 1ns/1ps
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [2*DW-1:0] cnt,
    input  logic            running,
    input  logic            to_flag,
    output logic [DW-1:0]   rdata,
    output logic            int_en,
    output logic            cont_mode,
    output logic            start_cmd,
    output logic            stop_cmd,
    output logic            to_clr,
    output logic            per_wr,
    output logic [2*DW-1:0] per_q,
    output logic [2*DW-1:0] per_load
);
    localparam int CW = 2 * DW;

    logic          wr;
    logic          ctrl_wr, lo_wr, hi_wr, snap_wr;
    logic [CW-1:0] snap_q;

    assign wr        = sel && wr_en;
    assign to_clr    = wr && (addr == AW'(OFS_STATUS));
    assign ctrl_wr   = wr && (addr == AW'(OFS_CONTROL));
    assign lo_wr     = wr && (addr == AW'(OFS_PER_LO));
    assign hi_wr     = wr && (addr == AW'(OFS_PER_HI));
    assign snap_wr   = wr && ((addr == AW'(OFS_SNAP_LO)) || (addr == AW'(OFS_SNAP_HI)));
    assign per_wr    = lo_wr || hi_wr;
    assign start_cmd = ctrl_wr && wdata[CTL_START];
    assign stop_cmd  = ctrl_wr && wdata[CTL_STOP];

    // merged period as it will stand after this edge
    always_comb begin
        per_load = per_q;
        if (lo_wr) per_load[DW-1:0]  = wdata;
        if (hi_wr) per_load[CW-1:DW] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q     <= '0;
            snap_q    <= '0;
            int_en    <= 1'b0;
            cont_mode <= 1'b0;
        end else begin
            if (per_wr)  per_q  <= per_load;
            if (snap_wr) snap_q <= cnt;
            if (ctrl_wr) begin
                int_en    <= wdata[CTL_IE];
                cont_mode <= wdata[CTL_CONT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(OFS_STATUS):  rdata = DW'({running, to_flag});
            AW'(OFS_CONTROL): rdata = DW'({cont_mode, int_en});
            AW'(OFS_PER_LO):  rdata = per_q[DW-1:0];
            AW'(OFS_PER_HI):  rdata = per_q[CW-1:DW];
            AW'(OFS_SNAP_LO): rdata = snap_q[DW-1:0];
            AW'(OFS_SNAP_HI): rdata = snap_q[CW-1:DW];
            default:          rdata = '0;
        endcase
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_wr |=> $stable(snap_q)); // R11
    AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        snap_wr |=> snap_q == $past(cnt)); // R11
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_cmd,
    input  logic          stop_cmd,
    input  logic          per_wr,
    input  logic          to_clr,
    input  logic          cont_mode,
    input  logic [CW-1:0] per_q,
    input  logic [CW-1:0] per_load,
    output logic [CW-1:0] cnt_q,
    output logic          running,
    output logic          to_q
);
    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic          quiet, expire;

    assign quiet   = !start_cmd && !stop_cmd && !per_wr;
    assign expire  = (state_q == ST_COUNT) && (cnt_q == '0) && quiet;
    assign running = (state_q == ST_COUNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (per_wr) begin                       // PERIOD_WRITE
            state_d = ST_IDLE;
            cnt_d   = per_load;
        end else if (stop_cmd) begin            // STOP (beats START)
            state_d = ST_IDLE;
        end else if (start_cmd) begin           // START
            state_d = ST_COUNT;
            cnt_d   = per_q;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_COUNT: begin
                    if (cnt_q == '0) begin
                        if (cont_mode) begin    // EXPIRE_RELOAD
                            state_d = ST_COUNT;
                            cnt_d   = per_q;
                        end else begin          // EXPIRE_HALT
                            state_d = ST_IDLE;
                        end
                    end else begin              // TICK
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (expire)      to_q <= 1'b1;
            else if (to_clr) to_q <= 1'b0;
        end
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !stop_cmd && !per_wr |=> running && cnt_q == $past(per_q)); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        running && cnt_q != '0 && quiet |=> running && cnt_q == $past(cnt_q) - 1'b1); // R3
    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        running && cnt_q == '0 && quiet && !cont_mode |=> !running && to_q); // R4
    AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        running && cnt_q == '0 && quiet && cont_mode |=> running && to_q && cnt_q == $past(per_q)); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !running && $stable(cnt_q)); // R6
    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        to_clr && !(running && cnt_q == '0 && quiet) |=> !to_q); // R8
    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        to_q && !to_clr |=> to_q); // R9
    AST_PER_WR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> !running && cnt_q == $past(per_load)); // R12
endmodule

// File: rtl/ivl_timer_top.sv
`timescale 1ns/1ps
module ivl_timer_top
    import tmr_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] cnt, per_q, per_load;
    logic running, to_flag, int_en, cont_mode;
    logic start_cmd, stop_cmd, to_clr, per_wr;

    tmr_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .cnt(cnt), .running(running), .to_flag(to_flag),
        .rdata(rdata), .int_en(int_en), .cont_mode(cont_mode),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .to_clr(to_clr),
        .per_wr(per_wr), .per_q(per_q), .per_load(per_load)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .per_wr(per_wr), .to_clr(to_clr), .cont_mode(cont_mode),
        .per_q(per_q), .per_load(per_load), .cnt_q(cnt),
        .running(running), .to_q(to_flag)
    );

    assign irq = to_flag && int_en;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $rose(to_flag) || $rose(int_en)); // R10
endmodule

// File: tb/tb_ivl_timer_top.sv
`timescale 1ns/1ps
module tb_ivl_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ivl_timer_top dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // write: presented in low phase, takes effect on next rising edge, returns at next falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wdata = '0;
    endtask

    // read: consumes 0.4 ns, no clock edge
    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        #0.4;
        v = rdata;
        sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", 32'(v), 32'h0);
            if (a == 2) @(negedge clk);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);
        @(negedge clk);
    endtask

    task automatic t_map();
        logic [15:0] v;
        wr(3'd2, 16'h1234);
        wr(3'd3, 16'hABCD);
        rd(3'd2, v); chk("R2 period low", 32'(v), 32'h1234);
        rd(3'd3, v); chk("R2 period high", 32'(v), 32'hABCD);
        wr(3'd1, 16'h0003);
        rd(3'd1, v); chk("R2 control readback", 32'(v), 32'h3);
        wr(3'd1, 16'h0000);
        rd(3'd1, v); chk("R2 control cleared", 32'(v), 32'h0);
        wr(3'd1, 16'h0001);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        rd(3'd6, v); chk("R13 offset 6 reads zero", 32'(v), 32'h0);
        rd(3'd1, v); chk("R13 control untouched", 32'(v), 32'h1);
        rd(3'd2, v); chk("R13 period untouched", 32'(v), 32'h1234);
        wr(3'd1, 16'h0000);
    endtask

    task automatic t_oneshot();
        logic [15:0] v;
        wr(3'd2, 16'h0005);
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'h0005);               // ie + start, returns at N0
        rd(3'd1, v); chk("R2 start bit reads zero", 32'(v), 32'h1);
        repeat (5) @(negedge clk);        // N5
        rd(3'd0, v); chk("R4 running before expiry", 32'(v), 32'h2);
        chk("R10 irq low before expiry", 32'(irq), 32'h0);
        @(negedge clk);                   // N6
        rd(3'd0, v); chk("R4 one-shot expiry status", 32'(v), 32'h1);
        chk("R10 irq with enable", 32'(irq), 32'h1);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R4 count held at zero", 32'(v), 32'h0);
        wr(3'd1, 16'h0000);
        chk("R10 irq off when disabled", 32'(irq), 32'h0);
        rd(3'd0, v); chk("R9 flag survives control write", 32'(v), 32'h1);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R9 flag sticky", 32'(v), 32'h1);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R8 status write clears", 32'(v), 32'h0);
    endtask

    task automatic t_snap_stop();
        logic [15:0] v;
        wr(3'd2, 16'h0010);
        wr(3'd3, 16'h0002);
        wr(3'd1, 16'h0004);               // start at E0, returns N0
        wr(3'd4, 16'h0000);               // captures at E1: P
        rd(3'd5, v); chk("R11 snapshot high", 32'(v), 32'h2);
        rd(3'd4, v); chk("R3 snapshot low at start", 32'(v), 32'h10);
        repeat (3) @(negedge clk);        // N4
        rd(3'd4, v); chk("R11 snapshot holds", 32'(v), 32'h10);
        wr(3'd4, 16'h0000);               // E5: P-4
        rd(3'd4, v); chk("R3 decrement", 32'(v), 32'hC);
        wr(3'd5, 16'h0000);               // E6: P-5
        rd(3'd4, v); chk("R11 capture via high offset", 32'(v), 32'hB);
        wr(3'd1, 16'h0008);               // stop at E7: count P-6 frozen
        rd(3'd0, v); chk("R6 stopped", 32'(v), 32'h0);
        repeat (5) @(negedge clk);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R6 count frozen", 32'(v), 32'hA);
        wr(3'd1, 16'h000C);               // start+stop
        rd(3'd0, v); chk("R7 stop wins over start", 32'(v), 32'h0);
        repeat (2) @(negedge clk);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R7 count unchanged", 32'(v), 32'hA);
    endtask

    task automatic t_period_write();
        logic [15:0] v;
        wr(3'd1, 16'h0004);
        repeat (4) @(negedge clk);
        wr(3'd2, 16'h0007);
        rd(3'd0, v); chk("R12 period write stops", 32'(v), 32'h0);
        repeat (2) @(negedge clk);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R12 new period loaded low", 32'(v), 32'h7);
        rd(3'd5, v); chk("R12 new period loaded high", 32'(v), 32'h2);
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_cont();
        logic [15:0] v;
        wr(3'd2, 16'h0003);
        wr(3'd1, 16'h0006);               // cont + start, returns N0
        repeat (4) @(negedge clk);        // N4
        rd(3'd0, v); chk("R5 expiry keeps running", 32'(v), 32'h3);
        chk("R10 irq low without enable", 32'(irq), 32'h0);
        wr(3'd0, 16'hFFFF);               // clear at E5
        rd(3'd0, v); chk("R8 clear with any data", 32'(v), 32'h2);
        repeat (3) @(negedge clk);        // N8
        rd(3'd0, v); chk("R5 periodic expiry", 32'(v), 32'h3);
        wr(3'd4, 16'h0000);               // E9 captures value after E8
        rd(3'd4, v); chk("R5 reload value", 32'(v), 32'h3);
        wr(3'd1, 16'h0008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_oneshot();
        t_snap_stop();
        t_period_write();
        t_cont();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule